// File: doc/BRIEF.md
# JESD204 Transport-Layer Frame Assembler

This block sits between the band-decimation stage and the lane encoders of one JESD204 link. It takes one set of complex samples per frame and spreads their octets over up to eight lanes. The set holds I and Q for up to four bands, and for more than one sample instant per frame when the mode calls for it. On each octet clock it emits one octet per lane, together with a start-of-frame flag. Scrambling, line coding, lane alignment and serialisation happen further down the path. Eight complex bands need two links, because a link carries at most eight converters, so a second instance handles bands E to H.

The mode comes from four small configuration fields. They give the converter count per link (M), the samples per converter per frame (S), the active lane count (L) and the resolution: 16 or 24 bits. The octets per lane per frame follow as F = M·S·B/L, where B is 2 or 3 octets per sample. Every mode in the 16-bit and 24-bit complex families has a legal encoding. Examples are 8-8-2-1, 4-8-4-1, 1-8-16-1, 8-2-1-2, 8-4-3-2 and 8-2-3-4.

The input side is a valid/ready stream with one sample set per beat. The output side is a valid/ready stream with one octet column per beat. When the consumer drops `m_ready`, the current column is held and the next sample set is refused. A new set is taken only while nothing is held, or in the same cycle as the last column of the current frame is consumed. Frames can therefore follow each other with no gap.

Top module: `jfa_frame_assembler`

## Requirements
- R1: `s_ready` is high exactly when reset is released and one of two conditions holds: no frame is held, or the final octet column of the held frame is being accepted (`m_ready` high). A sample set is captured on a cycle with `s_valid` and `s_ready` both high. `s_ready` is low during reset and while an output column is stalled.
- R2: While `m_valid` is high and `m_ready` is low, `m_octets`, `m_lane_valid` and `m_sof` stay unchanged on the following cycle.
- R3: The converter index is c = 2·band + q, with band A=0 to D=3, q=0 for I and q=1 for Q. Input slot j = s·M + c holds sample instant s of converter c in `s_samples[24*j +: 24]`. Octet k of the frame belongs to slot k/B, and the slots run in ascending order. In 16-bit mode (B=2) a slot gives bits [15:8] and then [7:0], and its bits [23:16] are ignored.
- R4: In octet column f (0..F-1) of a frame, lane l carries octet k = l·F + f. Here F = M·S·B/L, and lane l occupies `m_octets[8*l +: 8]`.
- R5: `m_sof` is high exactly on column 0 of each frame. That column appears on the cycle after the sample set is captured.
- R6: Lanes l ≥ L drive `m_lane_valid[l]` low and a zero octet. Lanes l < L drive `m_lane_valid[l]` equal to `m_valid`.
- R7: The fields encode log2 values: `cfg_conv_log` = log2 M (1..3), `cfg_samp_log` = log2 S (0..2) with M·S ≤ 8, and `cfg_lane_log` = log2 L (0..3). `cfg_wide`=1 selects 24-bit and 0 selects 16-bit. The fields are sampled only while `rst_n` is low, and changes made while reset is released have no effect on the output.
- R8: During reset, and when idle after a frame has drained, `m_valid`, `m_sof`, `m_lane_valid` and `m_octets` are all zero.
- R9: In 24-bit mode (B=3) a slot gives bits [23:16], then [15:8], then [7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Octet clock |
| rst_n | input | 1 | Synchronous active-low reset; also the window in which the mode is loaded |
| cfg_wide | input | 1 | 1 = 24-bit samples, 0 = 16-bit samples |
| cfg_conv_log | input | 2 | log2 of converters per link |
| cfg_samp_log | input | 2 | log2 of samples per converter per frame |
| cfg_lane_log | input | 2 | log2 of active lanes |
| s_valid | input | 1 | Sample set offered |
| s_ready | output | 1 | Sample set accepted this cycle when valid |
| s_samples | input | SLOTS*SAMPLE_W | Sample slots, slot j at [24*j +: 24] |
| m_valid | output | 1 | Octet column present |
| m_ready | input | 1 | Consumer takes the column |
| m_sof | output | 1 | Column 0 of a frame |
| m_lane_valid | output | LANES | Per-lane octet valid |
| m_octets | output | LANES*8 | Lane l octet at [8*l +: 8] |

## Verification
The hardest case to reach is a mode change attempted while frames are in flight. It must leave the lane mapping untouched, and nothing at the output shows that the configuration inputs were ignored. The bench changes the fields to a very different mode while reset is released and then pushes a frame. It compares every column against the mapping of the mode loaded during reset. A stall held over several cycles is also driven, along with a back-to-back handover on the last column, so that the refusal and acceptance edges of `s_ready` are each seen.

// File: rtl/jfa_pkg.sv
package jfa_pkg;

  localparam int unsigned OCTET_W = 8;

  typedef struct packed {
    logic       wide;      // 1: three octets per sample, 0: two
    logic [1:0] conv_log;  // log2 converters per link
    logic [1:0] samp_log;  // log2 samples per converter per frame
    logic [1:0] lane_log;  // log2 active lanes
  } jfa_cfg_t;

endpackage

// File: rtl/jfa_cfg_decode.sv
module jfa_cfg_decode
  import jfa_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned W_OCT  = 3,
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned AW     = 8
) (
  input  jfa_cfg_t           cfg,
  output logic [IDX_W-1:0]   frame_len,
  output logic [LANES-1:0]   lane_mask
);

  localparam int unsigned LW = $clog2(LANES) + 1;

  logic [2:0]    slot_log;
  logic [AW-1:0] slots_used;
  logic [AW-1:0] oct_total;

  always_comb begin
    slot_log   = {1'b0, cfg.conv_log} + {1'b0, cfg.samp_log};
    slots_used = AW'(1) << slot_log;
    oct_total  = cfg.wide ? slots_used * AW'(W_OCT)
                          : slots_used * AW'(W_OCT - 1);
    frame_len  = IDX_W'(oct_total >> cfg.lane_log);
  end

  for (genvar l = 0; l < LANES; l++) begin : g_mask
    assign lane_mask[l] = ((LW'(l) >> cfg.lane_log) == '0);
  end

endmodule

// File: rtl/jfa_octet_pack.sv
module jfa_octet_pack #(
  parameter int unsigned SLOTS    = 8,
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                               wide,
  input  logic [SLOTS*SAMPLE_W-1:0]          samples,
  output logic [SLOTS*(SAMPLE_W/8)*8-1:0]    octets
);

  localparam int unsigned W_OCT = SAMPLE_W / 8;
  localparam int unsigned N_OCT = W_OCT - 1;
  localparam int unsigned TOT   = SLOTS * W_OCT;

  logic [TOT*8-1:0] p_wide;
  logic [TOT*8-1:0] p_narrow;

  for (genvar j = 0; j < SLOTS; j++) begin : g_slot
    for (genvar b = 0; b < W_OCT; b++) begin : g_wide
      assign p_wide[(j*W_OCT + b)*8 +: 8] =
        samples[j*SAMPLE_W + (W_OCT-1-b)*8 +: 8];
    end
    for (genvar b = 0; b < N_OCT; b++) begin : g_narrow
      assign p_narrow[(j*N_OCT + b)*8 +: 8] =
        samples[j*SAMPLE_W + (N_OCT-1-b)*8 +: 8];
    end
  end

  assign p_narrow[TOT*8-1 : SLOTS*N_OCT*8] = '0;

  assign octets = wide ? p_wide : p_narrow;

endmodule

// File: rtl/jfa_lane_mux.sv
module jfa_lane_mux #(
  parameter int unsigned LANES = 8,
  parameter int unsigned TOT   = 24,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned AW    = 8
) (
  input  logic [TOT*8-1:0]   frame_buf,
  input  logic [IDX_W-1:0]   frame_len,
  input  logic [IDX_W-1:0]   slot,
  input  logic [LANES-1:0]   lane_en,
  output logic [LANES*8-1:0] lane_octets
);

  localparam int unsigned IW = $clog2(TOT);

  logic [7:0] oct_arr [TOT];

  for (genvar k = 0; k < TOT; k++) begin : g_arr
    assign oct_arr[k] = frame_buf[k*8 +: 8];
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [AW-1:0] idx;
    assign idx = AW'(l) * AW'(frame_len) + AW'(slot);
    assign lane_octets[l*8 +: 8] =
      (lane_en[l] && (idx < AW'(TOT))) ? oct_arr[idx[IW-1:0]] : 8'h00;
  end

endmodule

// File: rtl/jfa_frame_ctrl.sv
module jfa_frame_ctrl #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic             m_ready,
  input  logic [IDX_W-1:0] frame_len,
  output logic             s_ready,
  output logic             load,
  output logic             busy,
  output logic [IDX_W-1:0] slot
);

  logic last_col;

  assign last_col = (slot == frame_len - IDX_W'(1));
  assign s_ready  = rst_n && (!busy || (m_ready && last_col));
  assign load     = s_valid && s_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      slot <= '0;
    end else if (load) begin
      busy <= 1'b1;
      slot <= '0;
    end else if (busy && m_ready) begin
      if (last_col) begin
        busy <= 1'b0;
        slot <= '0;
      end else begin
        slot <= slot + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/jfa_frame_assembler.sv
module jfa_frame_assembler
  import jfa_pkg::*;
#(
  parameter int unsigned LANES    = 8,
  parameter int unsigned SLOTS    = 8,
  parameter int unsigned SAMPLE_W = 24
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_wide,
  input  logic [1:0]                cfg_conv_log,
  input  logic [1:0]                cfg_samp_log,
  input  logic [1:0]                cfg_lane_log,
  input  logic                      s_valid,
  output logic                      s_ready,
  input  logic [SLOTS*SAMPLE_W-1:0] s_samples,
  output logic                      m_valid,
  input  logic                      m_ready,
  output logic                      m_sof,
  output logic [LANES-1:0]          m_lane_valid,
  output logic [LANES*8-1:0]        m_octets
);

  localparam int unsigned W_OCT = SAMPLE_W / 8;
  localparam int unsigned TOT   = SLOTS * W_OCT;
  localparam int unsigned IDX_W = $clog2(TOT + 1);
  localparam int unsigned AW    = $clog2(LANES * TOT);

  jfa_cfg_t         cfg_q;
  logic [IDX_W-1:0] frame_len;
  logic [LANES-1:0] lane_mask;
  logic [TOT*8-1:0] packed_oct;
  logic [TOT*8-1:0] frame_buf;
  logic             load;
  logic             busy;
  logic [IDX_W-1:0] slot;

  // Mode is captured only while reset is held.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q <= '{wide: cfg_wide, conv_log: cfg_conv_log,
                 samp_log: cfg_samp_log, lane_log: cfg_lane_log};
    end
  end

  jfa_cfg_decode #(
    .LANES(LANES), .W_OCT(W_OCT), .IDX_W(IDX_W), .AW(AW)
  ) u_decode (
    .cfg       (cfg_q),
    .frame_len (frame_len),
    .lane_mask (lane_mask)
  );

  jfa_octet_pack #(
    .SLOTS(SLOTS), .SAMPLE_W(SAMPLE_W)
  ) u_pack (
    .wide    (cfg_q.wide),
    .samples (s_samples),
    .octets  (packed_oct)
  );

  jfa_frame_ctrl #(
    .IDX_W(IDX_W)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .m_ready   (m_ready),
    .frame_len (frame_len),
    .s_ready   (s_ready),
    .load      (load),
    .busy      (busy),
    .slot      (slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_buf <= '0;
    end else if (load) begin
      frame_buf <= packed_oct;
    end
  end

  assign m_valid      = busy;
  assign m_sof        = busy && (slot == '0);
  assign m_lane_valid = lane_mask & {LANES{busy}};

  jfa_lane_mux #(
    .LANES(LANES), .TOT(TOT), .IDX_W(IDX_W), .AW(AW)
  ) u_mux (
    .frame_buf   (frame_buf),
    .frame_len   (frame_len),
    .slot        (slot),
    .lane_en     (m_lane_valid),
    .lane_octets (m_octets)
  );

endmodule

// File: rtl/jfa_frame_assembler_chk.sv
module jfa_frame_assembler_chk
  import jfa_pkg::*;
#(
  parameter int unsigned LANES = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               s_valid,
  input logic               s_ready,
  input logic               m_valid,
  input logic               m_ready,
  input logic               m_sof,
  input logic [LANES-1:0]   m_lane_valid,
  input logic [LANES*8-1:0] m_octets,
  input jfa_cfg_t           run_cfg
);

  logic [LANES*8-1:0] valid_bits;
  for (genvar l = 0; l < LANES; l++) begin : g_bits
    assign valid_bits[l*8 +: 8] = {8{m_lane_valid[l]}};
  end

  AST_STALL_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);  // R1

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_octets) && $stable(m_sof)
                               && $stable(m_lane_valid)));  // R2

  AST_SOF_FOLLOWS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> (m_sof && m_valid));  // R5

  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> ($countones(m_lane_valid) == (1 << run_cfg.lane_log)));  // R6

  AST_QUIET_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_octets & ~valid_bits) == '0));  // R6

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(run_cfg));  // R7

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rst_n |=> (!m_valid && !m_sof && (m_lane_valid == '0)));  // R8

endmodule

bind jfa_frame_assembler jfa_frame_assembler_chk #(.LANES(LANES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .s_valid      (s_valid),
  .s_ready      (s_ready),
  .m_valid      (m_valid),
  .m_ready      (m_ready),
  .m_sof        (m_sof),
  .m_lane_valid (m_lane_valid),
  .m_octets     (m_octets),
  .run_cfg      (cfg_q)
);

// File: tb/jfa_frame_assembler_bench.sv
module jfa_frame_assembler_bench;

  localparam int LANES = 8;
  localparam int SLOTS = 8;
  localparam int SW    = 24;
  localparam int NMODE = 24;

  // {wide, conv_log, samp_log, lane_log}
  localparam logic [6:0] MODES [NMODE] = '{
    7'b0_11_00_11, 7'b0_11_00_10, 7'b0_11_00_01, 7'b0_11_00_00,
    7'b0_10_00_11, 7'b0_10_00_10, 7'b0_10_00_01, 7'b0_10_00_00,
    7'b0_01_01_11, 7'b0_01_00_10, 7'b0_01_00_01, 7'b0_01_00_00,
    7'b1_11_00_11, 7'b1_11_00_10, 7'b1_11_00_01, 7'b1_11_00_00,
    7'b1_10_01_11, 7'b1_10_00_10, 7'b1_10_00_01, 7'b1_10_00_00,
    7'b1_01_10_11, 7'b1_01_01_10, 7'b1_01_00_01, 7'b1_01_00_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wide = 1'b0;
  logic [1:0] cfg_conv_log = 2'd3, cfg_samp_log = 2'd0, cfg_lane_log = 2'd3;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [SLOTS*SW-1:0] s_samples = '0;
  logic m_valid;
  logic m_ready = 1'b1;
  logic m_sof;
  logic [LANES-1:0] m_lane_valid;
  logic [LANES*8-1:0] m_octets;

  int total = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  jfa_frame_assembler u_jfa_frame_assembler (
    .clk(clk), .rst_n(rst_n), .cfg_wide(cfg_wide), .cfg_conv_log(cfg_conv_log),
    .cfg_samp_log(cfg_samp_log), .cfg_lane_log(cfg_lane_log),
    .s_valid(s_valid), .s_ready(s_ready), .s_samples(s_samples),
    .m_valid(m_valid), .m_ready(m_ready), .m_sof(m_sof),
    .m_lane_valid(m_lane_valid), .m_octets(m_octets)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] pat(int fr, int j);
    return {8'(16 + fr*8 + j), 8'(64 + fr*8 + j), 8'(128 + fr*8 + j)};
  endfunction

  function automatic logic [SLOTS*SW-1:0] frame_data(int fr);
    logic [SLOTS*SW-1:0] v;
    for (int j = 0; j < SLOTS; j++) v[j*SW +: SW] = pat(fr, j);
    return v;
  endfunction

  function automatic int oct_per(logic [6:0] md);
    return md[6] ? 3 : 2;
  endfunction

  function automatic int flen(logic [6:0] md);
    return ((1 << (md[5:4] + md[3:2])) * oct_per(md)) >> md[1:0];
  endfunction

  function automatic logic [7:0] lane_mask_of(logic [6:0] md);
    return 8'((1 << (1 << md[1:0])) - 1);
  endfunction

  function automatic logic [63:0] exp_col(logic [6:0] md, int fr, int f);
    logic [63:0] v;
    int b = oct_per(md);
    int nl = 1 << md[1:0];
    int fl = flen(md);
    v = '0;
    for (int l = 0; l < nl; l++) begin
      int k = l*fl + f;
      logic [23:0] s = pat(fr, k / b);
      v[l*8 +: 8] = s[8*(b - 1 - (k % b)) +: 8];
    end
    return v;
  endfunction

  task automatic set_cfg(logic [6:0] md);
    cfg_wide = md[6]; cfg_conv_log = md[5:4];
    cfg_samp_log = md[3:2]; cfg_lane_log = md[1:0];
  endtask

  task automatic apply_mode(logic [6:0] md);
    rst_n = 1'b0;
    set_cfg(md);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic check_col(logic [6:0] md, int fr, int f);
    string t = md[6] ? "R9/R4" : "R3/R4";
    chk(t, m_octets, exp_col(md, fr, f));
    chk("R5", {63'd0, m_sof}, {63'd0, f == 0});
    chk("R6", {56'd0, m_lane_valid}, {56'd0, lane_mask_of(md)});
  endtask

  task automatic run_frame(logic [6:0] md, int fr);
    s_valid = 1'b1;
    s_samples = frame_data(fr);
    #1 chk("R1", {63'd0, s_ready}, 64'd1);
    @(negedge clk);
    s_valid = 1'b0;
    for (int f = 0; f < flen(md); f++) begin
      check_col(md, fr, f);
      @(negedge clk);
    end
    chk("R8", {m_octets}, 64'd0);
    chk("R8", {62'd0, m_valid, m_sof}, 64'd0);
  endtask

  initial begin
    logic [6:0] dm;
    m_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", {55'd0, m_lane_valid, m_valid}, 64'd0);
    chk("R8", m_octets, 64'd0);
    chk("R1", {63'd0, s_ready}, 64'd0);

    // Table of modes, one frame each.
    for (int i = 0; i < NMODE; i++) begin
      apply_mode(MODES[i]);
      run_frame(MODES[i], i);
    end

    // Directed: stall and back-to-back in 4-8-4-1, 16-bit.
    dm = 7'b0_11_00_10;
    apply_mode(dm);
    s_valid = 1'b1; s_samples = frame_data(40);
    @(negedge clk);
    s_valid = 1'b0;
    check_col(dm, 40, 0);
    m_ready = 1'b0;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk("R2", m_octets, exp_col(dm, 40, 0));
      chk("R2", {63'd0, m_sof}, 64'd1);
      chk("R1", {63'd0, s_ready}, 64'd0);
    end
    m_ready = 1'b1;
    @(negedge clk); check_col(dm, 40, 1);
    @(negedge clk); check_col(dm, 40, 2);
    @(negedge clk); check_col(dm, 40, 3);
    #1 chk("R1", {63'd0, s_ready}, 64'd1);
    m_ready = 1'b0;
    #1 chk("R1", {63'd0, s_ready}, 64'd0);
    m_ready = 1'b1;
    s_valid = 1'b1; s_samples = frame_data(41);
    @(negedge clk);
    s_valid = 1'b0;
    for (int f = 0; f < 4; f++) begin
      check_col(dm, 41, f);
      @(negedge clk);
    end
    chk("R8", {62'd0, m_valid, m_sof}, 64'd0);

    // Directed: mode fields changed outside reset are ignored.
    set_cfg(7'b1_01_00_00);
    @(negedge clk);
    run_frame(dm, 42);
    chk("R7", {63'd0, m_valid}, 64'd0);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule